// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs the external bus cycle of a 16-bit core whose memory and I/O address shares its lines with data. A cycle runs through the states T1, T2, T3, any number of wait states and T4. In T1 the low address bits go out on the shared lines. The top address bits go out on a small group of combined address/status pins, and a latch-enable strobe marks the phase for external address latches. From T2 to T4 the shared lines carry write data, or are released so that read data can come in. The combined pins then carry cycle status, whose top bit marks a DMA cycle.

The bus-high-enable pin and address bit 0 together select the byte lanes. Wait states are added while a synchronized ready input stays low. A hold request is granted only between cycles. While it is granted, every pin group is floated.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the sequencer is idle. hlda_o, ale_o and done_o are 0, bhe_n_o is 1, and all three output enables are 1.
- R2: ale_o is high for exactly one cycle, which is T1. In T1, ad_o[15:1] equals address bits 15..1 and as_o equals address bits 19..16.
- R3: In T2, T3, wait states and T4, as_o[3] is 1 for a DMA cycle and 0 for a core cycle, and as_o[2:0] is 0.
- R4: Byte lanes in T1 follow {bhe_n_o, ad_o[0]}. A word transfer gives 0,0 whatever the address LSB. A byte with an odd address gives 0,1 (upper half). A byte with an even address gives 1,0 (lower half).
- R5: From T2 to T4, bhe_n_o keeps the value it had in T1.
- R6: On a write, ad_oe_o is 1 and ad_o carries the write data from T2 to T4.
- R7: On a read, ad_oe_o is 0 from T2 to T4. The value on ad_i at the end of the last data state before T4 appears on rsp_rdata_o while done_o is high.
- R8: Ready passes through SYNC_STAGES flops. The sequencer leaves T3 or a wait state only when the synchronized ready is 1. With the default of 2 stages, raising ready_i in cycle j after T1 (T1 being cycle 0) gives j wait states, so T1 to T4 takes 4+j cycles.
- R9: hlda_o rises only on the edge after idle or T4, never during a cycle. A request made while hold is asserted does not start until hold is released.
- R10: While hlda_o is 1, ad_oe_o, as_oe_o and bhe_oe_o are 0. Releasing hold_i drops hlda_o on the next edge.
- R11: done_o is high for exactly one cycle, T4, at the end of each bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Core requests a bus cycle; taken when idle and no hold |
| req_addr_i | input | 20 | Cycle address |
| req_write_i | input | 1 | 1 write, 0 read |
| req_byte_i | input | 1 | 1 byte transfer, 0 word |
| req_dma_i | input | 1 | Cycle belongs to DMA |
| req_wdata_i | input | 16 | Write data |
| ready_i | input | 1 | Asynchronous ready from the addressed device |
| hold_i | input | 1 | Bus hold request |
| hlda_o | output | 1 | Hold acknowledge |
| ale_o | output | 1 | Address phase strobe (T1) |
| done_o | output | 1 | T4 marker; read data valid |
| rsp_rdata_o | output | 16 | Captured read data |
| ad_i | input | 16 | Shared lines, input side |
| ad_o | output | 16 | Shared lines, output side |
| ad_oe_o | output | 1 | Shared lines drive enable |
| as_o | output | 4 | Upper address / status pins |
| as_oe_o | output | 1 | Address/status drive enable |
| bhe_n_o | output | 1 | Bus high enable / S7, active low |
| bhe_oe_o | output | 1 | bhe_n_o drive enable |

## Verification
The bench uses the default parameters: 20 address bits, 16 data bits and two ready synchronizer stages. With these values the number of wait states equals the index of the cycle in which ready rises. That lets the bench put exact lengths of 0, 1 and 2 wait states in its expected items. The 4-bit upper group gives a single status bit above three forced-low bits, so core and DMA cycles are told apart directly. Hold is exercised three ways: in idle, across a running cycle, and together with a pending request.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
  typedef enum logic [2:0] {
    ST_TI   = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } bus_state_e;
endpackage

// File: rtl/bus_ready_sync.sv
module bus_ready_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/bus_tstate_fsm.sv
module bus_tstate_fsm
  import mux_bus_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic       hold_i,
  input  logic       rdy_s_i,
  output bus_state_e state_o,
  output logic       accept_o,
  output logic       capture_o
);
  bus_state_e state_q, state_d;

  assign accept_o  = (state_q == ST_TI) && req_valid_i && !hold_i;
  assign capture_o = ((state_q == ST_T3) || (state_q == ST_TW)) && rdy_s_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TI:   if (hold_i) state_d = ST_HOLD;
               else if (req_valid_i) state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3,
      ST_TW:   state_d = rdy_s_i ? ST_T4 : ST_TW;
      ST_T4:   state_d = hold_i ? ST_HOLD : ST_TI;
      ST_HOLD: if (!hold_i) state_d = ST_TI;
      default: state_d = ST_TI;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_TI;
    else         state_q <= state_d;

  assign state_o = state_q;

  AST_HOLD_BETWEEN_CYCLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_HOLD) |-> ($past(state_q) == ST_TI || $past(state_q) == ST_T4)); // R9
  AST_WAIT_NEEDS_LOW_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TW) |-> !$past(rdy_s_i)); // R8
endmodule

// File: rtl/bus_pin_drive.sv
module bus_pin_drive
  import mux_bus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_state_e        state_i,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_byte_i,
  input  logic              req_dma_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] as_o,
  output logic              as_oe_o,
  output logic              bhe_n_o,
  output logic              bhe_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  localparam int UP_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addr_q;
  logic              write_q, byte_q, dma_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              lane_a0, lane_bhe_n, data_phase;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      byte_q  <= 1'b0;
      dma_q   <= 1'b0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= req_addr_i;
      write_q <= req_write_i;
      byte_q  <= req_byte_i;
      dma_q   <= req_dma_i;
      wdata_q <= req_wdata_i;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                   rdata_q <= '0;
    else if (capture_i && !write_q) rdata_q <= ad_i;

  // word: both lanes; byte: lane picked by address LSB
  assign lane_a0    = byte_q & addr_q[0];
  assign lane_bhe_n = byte_q & ~addr_q[0];
  assign data_phase = (state_i == ST_T2) || (state_i == ST_T3) ||
                      (state_i == ST_TW) || (state_i == ST_T4);

  always_comb begin
    ad_o     = '0;
    ad_oe_o  = 1'b1;
    as_o     = '0;
    as_oe_o  = 1'b1;
    bhe_n_o  = 1'b1;
    bhe_oe_o = 1'b1;
    if (state_i == ST_T1) begin
      ad_o    = {addr_q[DATA_W-1:1], lane_a0};
      as_o    = addr_q[ADDR_W-1:DATA_W];
      bhe_n_o = lane_bhe_n;
    end else if (data_phase) begin
      ad_o    = write_q ? wdata_q : '0;
      ad_oe_o = write_q;
      as_o    = {dma_q, {(UP_W-1){1'b0}}};
      bhe_n_o = lane_bhe_n;
    end else if (state_i == ST_HOLD) begin
      ad_oe_o  = 1'b0;
      as_oe_o  = 1'b0;
      bhe_oe_o = 1'b0;
    end
  end

  assign rdata_o = rdata_q;
  assign done_o  = (state_i == ST_T4);

  AST_S7_FOLLOWS_BHE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_T2) |-> (bhe_n_o == $past(bhe_n_o))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mux_bus_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_byte_i,
  input  logic              req_dma_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              ready_i,
  input  logic              hold_i,
  output logic              hlda_o,
  output logic              ale_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] as_o,
  output logic              as_oe_o,
  output logic              bhe_n_o,
  output logic              bhe_oe_o
);
  bus_state_e state;
  logic       rdy_s, accept, capture;

  bus_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ready_i), .sync_o(rdy_s)
  );

  bus_tstate_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .hold_i(hold_i),
    .rdy_s_i(rdy_s), .state_o(state), .accept_o(accept), .capture_o(capture)
  );

  bus_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state), .accept_i(accept),
    .capture_i(capture), .req_addr_i(req_addr_i), .req_write_i(req_write_i),
    .req_byte_i(req_byte_i), .req_dma_i(req_dma_i), .req_wdata_i(req_wdata_i),
    .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .as_o(as_o), .as_oe_o(as_oe_o),
    .bhe_n_o(bhe_n_o), .bhe_oe_o(bhe_oe_o), .rdata_o(rsp_rdata_o), .done_o(done_o)
  );

  assign hlda_o = (state == ST_HOLD);
  assign ale_o  = (state == ST_T1);

  AST_ALE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o); // R2
  AST_HOLD_FLOATS_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!ad_oe_o && !as_oe_o && !bhe_oe_o)); // R10
  AST_REQ_WAITS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hlda_o && hold_i) |=> !ale_o); // R9
endmodule

// File: tb/mux_bus_seq_test.sv
module mux_bus_seq_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [19:0] addr;
    logic        write;
    logic        byte_x;
    logic        dma;
    logic [15:0] data;
    int          waits;
  } item_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0, req_dma = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0, ad_in = '0;
  logic        ready = 1'b1, hold = 1'b0;
  logic        hlda, ale, done, ad_oe, as_oe, bhe_n, bhe_oe;
  logic [15:0] rdata, ad_out;
  logic [3:0]  as_out;

  int checks = 0, errors = 0;
  bit finished = 0;
  item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_byte_i(req_byte), .req_dma_i(req_dma),
    .req_wdata_i(req_wdata), .ready_i(ready), .hold_i(hold), .hlda_o(hlda),
    .ale_o(ale), .done_o(done), .rsp_rdata_o(rdata), .ad_i(ad_in), .ad_o(ad_out),
    .ad_oe_o(ad_oe), .as_o(as_out), .as_oe_o(as_oe), .bhe_n_o(bhe_n), .bhe_oe_o(bhe_oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // driver: push expected item, run request, release ready after waits cycles
  task automatic do_cycle(input logic [19:0] a, input logic w, input logic b,
                          input logic d, input logic [15:0] data, input int waits);
    item_t it;
    it.addr = a; it.write = w; it.byte_x = b; it.dma = d; it.data = data; it.waits = waits;
    exp_q.push_back(it);
    req_addr = a; req_write = w; req_byte = b; req_dma = d; req_wdata = data;
    ad_in = w ? 16'h0 : data;
    if (waits > 0) ready = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    while (!ale) @(negedge clk);
    req_valid = 1'b0;
    repeat (waits) @(negedge clk);
    ready = 1'b1;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && ale) begin
        item_t it;
        logic  exp_bhe, exp_a0;
        int    n;
        if (exp_q.size() == 0) begin
          check(0, "R2", "unexpected ale", 1, 0);
          continue;
        end
        it = exp_q.pop_front();
        exp_a0  = it.byte_x & it.addr[0];
        exp_bhe = it.byte_x & ~it.addr[0];
        check(ad_out[15:1] == it.addr[15:1], "R2", "T1 address", ad_out, it.addr[15:0]);
        check(as_out == it.addr[19:16], "R2", "T1 upper address", as_out, it.addr[19:16]);
        check({bhe_n, ad_out[0]} == {exp_bhe, exp_a0}, "R4", "byte lanes",
              {bhe_n, ad_out[0]}, {exp_bhe, exp_a0});
        n = 0;
        do begin
          @(negedge clk);
          n++;
          check(!ale, "R2", "ale width", ale, 0);
          check(as_out == {it.dma, 3'b000}, "R3", "status", as_out, {it.dma, 3'b000});
          check(bhe_n == exp_bhe, "R5", "S7 equals BHE", bhe_n, exp_bhe);
          check(!hlda, "R9", "hlda inside cycle", hlda, 0);
          check(ad_oe == it.write, "R6 R7", "ad_oe in data phase", ad_oe, it.write);
          if (it.write) check(ad_out == it.data, "R6", "write data", ad_out, it.data);
        end while (!done && n < 50);
        check(n == 3 + it.waits, "R8", "T2..T4 length", n, 3 + it.waits);
        if (!it.write) check(rdata == it.data, "R7", "read data", rdata, it.data);
        @(negedge clk);
        check(!done, "R11", "done width", done, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "WATCHDOG", "timeout", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!hlda && !ale && !done, "R1", "idle flags", {hlda, ale, done}, 0);
    check(bhe_n && ad_oe && as_oe && bhe_oe, "R1", "idle pins",
          {bhe_n, ad_oe, as_oe, bhe_oe}, 4'hf);

    do_cycle(20'hA1234, 1'b1, 1'b0, 1'b0, 16'hC3A5, 0); // word write, core
    do_cycle(20'h56789, 1'b0, 1'b1, 1'b1, 16'hBEEF, 2); // upper byte read, DMA
    do_cycle(20'hFFFFE, 1'b1, 1'b1, 1'b0, 16'h005A, 0); // lower byte write
    do_cycle(20'h00003, 1'b0, 1'b0, 1'b0, 16'h1357, 1); // word, odd address -> A0 0

    // R10 hold in idle
    hold = 1'b1;
    @(negedge clk);
    check(hlda, "R10", "hlda in idle hold", hlda, 1);
    check(!ad_oe && !as_oe && !bhe_oe, "R10", "pins floated", {ad_oe, as_oe, bhe_oe}, 0);
    hold = 1'b0;
    @(negedge clk);
    check(!hlda, "R10", "hlda release", hlda, 0);

    // R9 request pending during hold
    hold = 1'b1;
    @(negedge clk);
    fork
      begin
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          check(!ale && hlda, "R9", "no cycle while held", {ale, hlda}, 1);
        end
        hold = 1'b0;
      end
      do_cycle(20'h2468A, 1'b1, 1'b0, 1'b1, 16'h9ABC, 0);
    join

    // R9 hold raised inside a cycle: granted only after T4
    fork
      do_cycle(20'h13579, 1'b0, 1'b1, 1'b0, 16'h7E00, 1);
      begin
        @(negedge clk);
        while (!ale) @(negedge clk);
        @(negedge clk);
        hold = 1'b1;
        while (!done) @(negedge clk);
        check(!hlda, "R9", "hlda during T4", hlda, 0);
        @(negedge clk);
        check(hlda, "R9", "hlda after T4", hlda, 1);
        hold = 1'b0;
        @(negedge clk);
        check(!hlda, "R10", "hlda drop", hlda, 0);
      end
    join

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2", "all items seen", exp_q.size(), 0);
    summary();
  end
endmodule